// File: doc/BRIEF.md
# Enhanced parallel port host transfer controller

This block is the host end of an enhanced-mode parallel port link. A processor-style requester presents a single-byte transfer (data or address, read or write) and holds it; the controller runs the strobe/wait handshake on the port pins and stalls the requester until the byte has been moved. The direction of the eight data lines is switched by the handshake sequencer on its own: a write turns the output buffers on and pulls the write line low before any strobe, and a read turns the buffers off before its strobe so the peripheral can drive the lines.

A small control register lets software preset the port direction between transfers. A preset to output keeps the write line low and the buffers on while idle, so a following write strobe finds the write line already settled. A preset to input keeps the buffers off while idle. A peripheral that never answers is cut off after a fixed number of strobe cycles and reported through a sticky status bit. A programmable count of idle cycles is always inserted between one transfer and the next strobe.

Top module: `epp_host_ctrl`

## Requirements
- R1: A data transfer (`req_addr`=0) pulses only `dstb_n` low and an address transfer (`req_addr`=1) pulses only `astb_n` low; the two strobes are never low together and both are high out of reset.
- R2: In a write, `write_n` is low and `pd_oe` is high for at least one clock before the strobe falls and stay so while it is low, and the peripheral sees the requested byte on `pd_o`.
- R3: Once low, the strobe stays low until `wait_n` is sampled high, then rises on the next clock; with a peripheral that raises `wait_n` after d clocks of strobe the strobe is low for exactly d+2 clocks.
- R4: In a read, `pd_oe` is low for at least one clock before the strobe falls and while it is low, and `write_n` is high.
- R5: On a read, `req_rdata` holds the byte present on `pd_i` at the clock where `wait_n` is seen high, never the last byte written.
- R6: `req_wait` is high from a held request until the single clock where `req_done` is high; `req_done` is a one-clock pulse per transfer.
- R7: Control bits: bit0 enables the direction preset, bit1 selects input (1) or output (0). While idle, bit0=0 or bits=11 give `pd_oe`=0 and `write_n`=1; bits=01 give `pd_oe`=1 and `write_n`=0. During a transfer the automatic direction of R2/R4 applies regardless.
- R8: With output preset (bits=01), `write_n` stays low without a break from idle through the whole of a following write strobe.
- R9: If `wait_n` never rises, the strobe is held low for exactly TMO_CYC clocks, then released, `req_done` pulses, a read returns 0xFF and status bit2 of `cfg_rdata` becomes 1.
- R10: Status bit2 is sticky: a control write with `cfg_wdata[2]`=1 clears it, a control write with bit2=0 leaves it set.
- R11: Between the rise of one strobe and the fall of the next there are at least GAP_CYC+3 clocks with both strobes high, exactly GAP_CYC+3 when the next request is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request, held until `req_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 1 = address transfer, 0 = data transfer |
| req_wdata | input | DW | Byte to write |
| req_rdata | output | DW | Byte read |
| req_wait | output | 1 | Stall to the requester |
| req_done | output | 1 | Transfer complete pulse |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | bit0 preset enable, bit1 preset input, bit2 clear timeout |
| cfg_rdata | output | 3 | bit0/bit1 as written, bit2 timeout flag |
| pd_o | output | DW | Data lines, driven value |
| pd_i | input | DW | Data lines, pin value |
| pd_oe | output | 1 | Data line output enable |
| write_n | output | 1 | Active-low write line |
| dstb_n | output | 1 | Active-low data strobe |
| astb_n | output | 1 | Active-low address strobe |
| wait_n | input | 1 | Peripheral handshake, high = cycle complete |

## Verification
Every clock, assertions check that the strobes are exclusive, that the direction lines are settled one clock before a strobe falls and stay stable under it, that a strobe is held until the handshake or timeout, that the requester is stalled under a strobe, that the timeout flag is sticky and that the idle gap between strobes is respected. Only the directed scenarios show which strobe a transfer uses, the exact strobe lengths for a given peripheral delay and for a hang, that read data comes from the pins, the idle levels under each preset, and the exact gap for back-to-back requests.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } epp_state_e;

  // control register bit positions
  localparam int CFG_PRESET_EN = 0;
  localparam int CFG_PRESET_IN = 1;
  localparam int CFG_TMO       = 2;

  // output buffer enable: transfer direction wins, preset applies when idle
  function automatic logic buf_enable(input logic active, input logic write,
                                      input logic pre_en, input logic pre_in);
    return active ? write : (pre_en & ~pre_in);
  endfunction

  // strobe-high clocks between two strobes when the next request waits
  function automatic int unsigned min_high_gap(input int unsigned gap);
    return gap + 3;
  endfunction

endpackage

// File: rtl/epp_ctl_reg.sv
module epp_ctl_reg
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  input  logic       tmo_evt,
  output logic       pre_en,
  output logic       pre_in,
  output logic       tmo_flag,
  output logic [2:0] cfg_rdata
);

  logic pre_en_q, pre_in_q, tmo_q;
  logic clr_req;

  assign clr_req = cfg_we & cfg_wdata[CFG_TMO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en_q <= 1'b0;
      pre_in_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      if (cfg_we) begin
        pre_en_q <= cfg_wdata[CFG_PRESET_EN];
        pre_in_q <= cfg_wdata[CFG_PRESET_IN];
      end
      if (tmo_evt)      tmo_q <= 1'b1;
      else if (clr_req) tmo_q <= 1'b0;
    end
  end

  assign pre_en   = pre_en_q;
  assign pre_in   = pre_in_q;
  assign tmo_flag = tmo_q;
  always_comb begin
    cfg_rdata                = '0;
    cfg_rdata[CFG_PRESET_EN] = pre_en_q;
    cfg_rdata[CFG_PRESET_IN] = pre_in_q;
    cfg_rdata[CFG_TMO]       = tmo_q;
  end

  AST_TMO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_flag); // R9
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !clr_req |=> tmo_flag); // R10
  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !tmo_evt |=> !tmo_flag); // R10

endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TMO_CYC = 64,
  parameter int GAP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] pd_i,
  input  logic          wait_n,
  output logic          cyc_active,
  output logic          cyc_write,
  output logic          cyc_addr,
  output logic          strobe_on,
  output logic          done,
  output logic          tmo_evt,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int TW = $clog2(TMO_CYC + 2);
  localparam int GW = $clog2(GAP_CYC + 2);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC);

  epp_state_e    state_q, state_d;
  logic [TW-1:0] tmo_cnt_q;
  logic [GW-1:0] gap_cnt_q;
  logic          wr_q, adr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  // named internal events
  logic gap_clear, accept, ack, tmo_hit;
  assign gap_clear = (gap_cnt_q == '0);
  assign accept    = (state_q == ST_IDLE) && req_valid && gap_clear;
  assign ack       = (state_q == ST_STROBE) && wait_n;
  assign tmo_hit   = (state_q == ST_STROBE) && !wait_n && (tmo_cnt_q == TMO_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (ack || tmo_hit) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tmo_cnt_q <= '0;
      gap_cnt_q <= '0;
      wr_q      <= 1'b0;
      adr_q     <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wr_q  <= req_write;
        adr_q <= req_addr;
        if (req_write) wdata_q <= req_wdata;
      end
      if (state_q == ST_STROBE && !ack && !tmo_hit) tmo_cnt_q <= tmo_cnt_q + 1'b1;
      else if (state_q != ST_STROBE)                tmo_cnt_q <= '0;
      if (ack && !wr_q)     rdata_q <= pd_i;
      if (tmo_hit && !wr_q) rdata_q <= '1;
      if (state_q == ST_DONE)                      gap_cnt_q <= GAP_LOAD;
      else if (state_q == ST_IDLE && !gap_clear)   gap_cnt_q <= gap_cnt_q - 1'b1;
    end
  end

  assign cyc_active = (state_q != ST_IDLE);
  assign cyc_write  = wr_q;
  assign cyc_addr   = adr_q;
  assign strobe_on  = (state_q == ST_STROBE);
  assign done       = (state_q == ST_DONE);
  assign tmo_evt    = tmo_hit;
  assign wdata      = wdata_q;
  assign rdata      = rdata_q;

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on && !wait_n && !tmo_hit |=> strobe_on); // R3
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> done && !strobe_on); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> tmo_cnt_q < TW'(TMO_CYC)); // R9
  AST_GAP_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> $past(gap_clear)); // R11

endmodule

// File: rtl/epp_pin_drive.sv
module epp_pin_drive
  import epp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cyc_active,
  input  logic          cyc_write,
  input  logic          cyc_addr,
  input  logic          strobe_on,
  input  logic          pre_en,
  input  logic          pre_in,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe,
  output logic          write_n,
  output logic          dstb_n,
  output logic          astb_n
);

  logic drive;
  assign drive   = buf_enable(cyc_active, cyc_write, pre_en, pre_in);
  assign pd_oe   = drive;
  assign write_n = ~drive;
  assign pd_o    = wdata;
  assign dstb_n  = ~(strobe_on & ~cyc_addr);
  assign astb_n  = ~(strobe_on &  cyc_addr);

endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl
  import epp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TMO_CYC = 64,
  parameter int GAP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_rdata,
  output logic          req_wait,
  output logic          req_done,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_wdata,
  output logic [2:0]    cfg_rdata,
  output logic [DW-1:0] pd_o,
  input  logic [DW-1:0] pd_i,
  output logic          pd_oe,
  output logic          write_n,
  output logic          dstb_n,
  output logic          astb_n,
  input  logic          wait_n
);

  localparam int HW = $clog2(GAP_CYC + 4) + 1;
  localparam logic [HW-1:0] HI_MIN = HW'(min_high_gap(GAP_CYC));

  logic cyc_active, cyc_write, cyc_addr, strobe_on, done, tmo_evt;
  logic pre_en, pre_in, tmo_flag;
  logic [DW-1:0] wdata;

  epp_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tmo_evt(tmo_evt), .pre_en(pre_en), .pre_in(pre_in),
    .tmo_flag(tmo_flag), .cfg_rdata(cfg_rdata)
  );

  epp_cycle_fsm #(.DW(DW), .TMO_CYC(TMO_CYC), .GAP_CYC(GAP_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pd_i(pd_i), .wait_n(wait_n),
    .cyc_active(cyc_active), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .strobe_on(strobe_on), .done(done), .tmo_evt(tmo_evt),
    .wdata(wdata), .rdata(req_rdata)
  );

  epp_pin_drive #(.DW(DW)) u_pins (
    .cyc_active(cyc_active), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .strobe_on(strobe_on), .pre_en(pre_en), .pre_in(pre_in), .wdata(wdata),
    .pd_o(pd_o), .pd_oe(pd_oe), .write_n(write_n),
    .dstb_n(dstb_n), .astb_n(astb_n)
  );

  assign req_wait = req_valid & ~done;
  assign req_done = done;

  // pin-level watchers for the assertions
  logic          strobe_low;
  logic [HW-1:0] hi_cnt_q;
  logic          seen_strobe_q;
  assign strobe_low = ~dstb_n | ~astb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q      <= '0;
      seen_strobe_q <= 1'b0;
    end else begin
      if (strobe_low) begin
        hi_cnt_q      <= '0;
        seen_strobe_q <= 1'b1;
      end else if (hi_cnt_q != '1) begin
        hi_cnt_q <= hi_cnt_q + 1'b1;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dstb_n && !astb_n)); // R1
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_low) && !write_n |-> $past(!write_n && pd_oe)); // R2
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low && $past(strobe_low) |-> $stable(pd_oe) && $stable(write_n)); // R2
  AST_RD_BUF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_low) && write_n |-> $past(!pd_oe) && !pd_oe); // R4
  AST_HOST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low && req_valid |-> req_wait); // R6
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_low) && seen_strobe_q |-> hi_cnt_q >= HI_MIN); // R11

endmodule

// File: tb/epp_host_ctrl_test.sv
module epp_host_ctrl_test;

  localparam int DW  = 8;
  localparam int TMO = 16;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_addr = 0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] req_rdata;
  logic req_wait, req_done;
  logic cfg_we = 0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic [DW-1:0] pd_o, pd_i;
  logic pd_oe, write_n, dstb_n, astb_n;
  logic wait_n;

  always #10 clk = ~clk;

  epp_host_ctrl #(.DW(DW), .TMO_CYC(TMO), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .req_wait(req_wait), .req_done(req_done), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pd_o(pd_o), .pd_i(pd_i),
    .pd_oe(pd_oe), .write_n(write_n), .dstb_n(dstb_n), .astb_n(astb_n),
    .wait_n(wait_n)
  );

  // peripheral model
  int            p_delay = 0;
  bit            p_hang  = 0;
  int            p_cnt   = 0;
  logic [DW-1:0] p_byte  = 8'h00;
  logic [DW-1:0] cap_byte = 8'h00;
  logic          cap_addr = 1'b0;
  logic          wait_q   = 1'b0;
  assign wait_n = wait_q;
  assign pd_i   = p_byte;

  always @(posedge clk) begin
    if (!dstb_n || !astb_n) begin
      if (!p_hang && p_cnt >= p_delay) begin
        wait_q <= 1'b1;
        if (!write_n && pd_oe) begin
          cap_byte <= pd_o;
          cap_addr <= !astb_n;
        end
      end else begin
        p_cnt <= p_cnt + 1;
      end
    end else begin
      p_cnt  <= 0;
      wait_q <= 1'b0;
    end
  end

  // strobe-high run monitor
  int hi_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (!dstb_n || !astb_n) begin
      if (hi_run > 0) last_hi = hi_run;
      hi_run = 0;
    end else begin
      hi_run = hi_run + 1;
    end
  end

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  // one transfer; returns read byte, strobe-low count and per-cycle pin checks
  task automatic xfer(input bit wr, input bit adr, input logic [7:0] b,
                      output logic [7:0] rd, output int lo_cnt,
                      output bit dir_ok, output bit stb_ok, output bit wait_ok,
                      output bit wn_always_low);
    bit prev_oe, prev_wn, first;
    int guard;
    rd = '0; lo_cnt = 0; dir_ok = 1; stb_ok = 1; wait_ok = 1;
    prev_oe = pd_oe; prev_wn = write_n; first = 1;
    wn_always_low = !write_n;
    req_valid = 1; req_write = wr; req_addr = adr; req_wdata = b;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
      if (write_n) wn_always_low = 0;
      if (!dstb_n || !astb_n) begin
        lo_cnt++;
        if (adr ? (astb_n || !dstb_n) : (dstb_n || !astb_n)) stb_ok = 0;
        if (wr) begin
          if (write_n || !pd_oe) dir_ok = 0;
          if (first && (prev_wn || !prev_oe)) dir_ok = 0;
        end else begin
          if (!write_n || pd_oe) dir_ok = 0;
          if (first && prev_oe) dir_ok = 0;
        end
        first = 0;
      end
      if (!req_done && !req_wait) wait_ok = 0;
      if (req_done && req_wait) wait_ok = 0;
      prev_oe = pd_oe; prev_wn = write_n;
    end while (!req_done && guard < 1000);
    rd = req_rdata;
    req_valid = 0;
    @(negedge clk);
    if (req_done) wait_ok = 0;
  endtask

  logic [7:0] rd;
  int lo;
  bit d_ok, s_ok, w_ok, wl;

  task automatic t_reset;
    chk(dstb_n && astb_n, "R1 strobes idle after reset", {dstb_n, astb_n}, 2'b11);
    chk(!pd_oe && write_n, "R7 idle direction after reset", {pd_oe, write_n}, 2'b01);
    chk(!req_wait && !req_done, "R6 no stall after reset", {req_wait, req_done}, 0);
    chk(cfg_rdata == 3'b000, "R10 status clear after reset", cfg_rdata, 0);
  endtask

  task automatic t_data_write;
    p_delay = 0;
    xfer(1, 0, 8'hC3, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(s_ok, "R1 data write uses data strobe only", s_ok, 1);
    chk(d_ok, "R2 write direction before and during strobe", d_ok, 1);
    chk(cap_byte == 8'hC3 && !cap_addr, "R2 peripheral got byte", cap_byte, 8'hC3);
    chk(lo == 2, "R3 strobe length with delay 0", lo, 2);
    chk(w_ok, "R6 stall until done", w_ok, 1);
  endtask

  task automatic t_addr_write;
    p_delay = 3;
    xfer(1, 1, 8'h3C, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(s_ok, "R1 address write uses address strobe only", s_ok, 1);
    chk(cap_byte == 8'h3C && cap_addr, "R2 address byte captured", cap_byte, 8'h3C);
    chk(lo == 5, "R3 strobe length with delay 3", lo, 5);
    chk(w_ok, "R6 stall on address write", w_ok, 1);
  endtask

  task automatic t_reads;
    p_delay = 1; p_byte = 8'h5A;
    xfer(0, 0, 8'h00, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(s_ok, "R1 data read uses data strobe only", s_ok, 1);
    chk(d_ok, "R4 buffers off before read strobe", d_ok, 1);
    chk(rd == 8'h5A, "R5 read returns pin value", rd, 8'h5A);
    chk(lo == 3, "R3 strobe length with delay 1", lo, 3);
    p_delay = 4; p_byte = 8'hA7;
    xfer(0, 1, 8'h00, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(s_ok, "R1 address read uses address strobe only", s_ok, 1);
    chk(d_ok && w_ok, "R4 address read direction and stall", {d_ok, w_ok}, 2'b11);
    chk(rd == 8'hA7, "R5 address read byte", rd, 8'hA7);
  endtask

  task automatic t_override;
    p_delay = 0;
    cfg_write(3'b011);
    chk(!pd_oe && write_n, "R7 preset input keeps buffers off", {pd_oe, write_n}, 2'b01);
    xfer(1, 0, 8'h96, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(d_ok && cap_byte == 8'h96, "R7 write overrides input preset", cap_byte, 8'h96);
    chk(!pd_oe && write_n, "R7 back to input after write", {pd_oe, write_n}, 2'b01);
    cfg_write(3'b001);
    chk(pd_oe && !write_n, "R7 preset output drives while idle", {pd_oe, write_n}, 2'b10);
    xfer(1, 0, 8'h69, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(wl, "R8 write line never leaves low under output preset", wl, 1);
    chk(cap_byte == 8'h69, "R8 byte under preset", cap_byte, 8'h69);
    p_byte = 8'h1E;
    xfer(0, 0, 8'h00, rd, lo, d_ok, s_ok, w_ok, wl);
    chk(d_ok && rd == 8'h1E, "R4 read turns buffers off under output preset", rd, 8'h1E);
    cfg_write(3'b000);
    chk(!pd_oe && write_n, "R7 preset disabled idles as input", {pd_oe, write_n}, 2'b01);
  endtask

  task automatic t_timeout;
    p_hang = 1;
    xfer(0, 0, 8'h00, rd, lo, d_ok, s_ok, w_ok, wl);
    p_hang = 0;
    chk(lo == TMO, "R9 strobe held for timeout length", lo, TMO);
    chk(rd == 8'hFF, "R9 timed out read returns all ones", rd, 8'hFF);
    chk(w_ok, "R9 requester released on timeout", w_ok, 1);
    chk(cfg_rdata[2], "R9 timeout flag set", cfg_rdata, 3'b100);
    cfg_write(3'b000);
    chk(cfg_rdata[2], "R10 flag survives write of zero", cfg_rdata, 3'b100);
    cfg_write(3'b100);
    chk(!cfg_rdata[2], "R10 write one clears flag", cfg_rdata, 3'b000);
  endtask

  task automatic t_gap;
    p_delay = 0;
    xfer(1, 0, 8'h11, rd, lo, d_ok, s_ok, w_ok, wl);
    // next request presented in the clock right after done
    req_valid = 1; req_write = 1; req_addr = 0; req_wdata = 8'h22;
    do @(negedge clk); while (!req_done);
    req_valid = 0;
    @(negedge clk);
    chk(cap_byte == 8'h22, "R11 second back-to-back byte", cap_byte, 8'h22);
    chk(last_hi >= GAP + 3, "R11 minimum idle gap", last_hi, GAP + 3);
  endtask

  task automatic t_gap_exact;
    p_delay = 0;
    req_valid = 1; req_write = 1; req_addr = 1; req_wdata = 8'h33;
    do @(negedge clk); while (!req_done);
    req_wdata = 8'h44;
    @(negedge clk);
    do @(negedge clk); while (!req_done);
    req_valid = 0;
    @(negedge clk);
    chk(last_hi == GAP + 3, "R11 exact gap with request held", last_hi, GAP + 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data_write();
    t_addr_write();
    t_reads();
    t_override();
    t_timeout();
    t_gap();
    t_gap_exact();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule